// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two binary32 operands. It returns a binary32 result together with four exception flags: invalid, overflow, underflow and inexact. A one-bit select chooses the operation. Subtraction is carried out by inverting the sign of the second operand and sending it through the same add datapath, so the unit has no separate subtractor. A two-bit input chooses among four rounding directions.

The arithmetic is combinational. The result and the flags are captured in output registers, so each result appears one clock after its operands. The datapath has the following stages:
- operand decoding, with subnormals treated as an implicit leading 0 and exponent 1
- magnitude ordering and alignment with guard, round and sticky bits
- a single add/subtract
- leading-zero normalisation that is clamped at the minimum exponent
- rounding, then an overflow stage

Special values (NaN, infinities and signed zeros) are resolved by a fixed priority ahead of the numeric result.

Top module: `fpas_top`

## Requirements
- R1: The result and all four flags are registered. Operands present before a rising edge produce their outputs at that edge. A synchronous active-high reset clears the result and all flags to zero.
- R2: `sub_sel` = 0 adds and `sub_sel` = 1 subtracts. Subtraction equals adding the second operand with bit 31 inverted.
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), the result is 0x7FC00000. Invalid is raised only when a NaN operand is signalling (fraction bit 22 clear). A NaN takes precedence over an infinity.
- R4: Two infinities whose effective signs differ produce 0x7FC00000 and raise invalid. This covers equal-signed infinities under subtraction. Otherwise an infinite operand is returned with its effective sign and no flag is raised.
- R5: An exact zero result from operands of differing effective sign is +0, except under `rnd_mode` 2'b11 (toward -infinity), where it is -0. The sum of two zeros of the same effective sign keeps that sign.
- R6: Subtracting +0 returns the other nonzero operand unchanged. Computing 0 minus x returns x with its sign inverted.
- R7: Results are correctly rounded by `rnd_mode`: 2'b00 is nearest with ties to even, 2'b01 is toward zero, 2'b10 is toward +infinity and 2'b11 is toward -infinity. Inexact is raised exactly when discarded bits are nonzero.
- R8: A difference of operands within a factor of two of each other, including massive cancellation, is exact and leaves inexact low.
- R9: On exponent overflow, overflow and inexact are both raised. Round-to-nearest gives infinity. A directed mode gives infinity when it rounds in the overflow direction, and the largest finite magnitude 0x7F7FFFFF with the result sign when it does not.
- R10: Subnormal operands are added exactly, including sums that carry into the normal range. Underflow is raised only for a result that is tiny before rounding and also inexact. Invalid is never accompanied by overflow or inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| rnd_mode | input | 2 | Rounding direction, encoded as in R7 |
| sum_out | output | 32 | Registered result, binary32 |
| invalid_o | output | 1 | Registered invalid-operation flag |
| overflow_o | output | 1 | Registered overflow flag |
| underflow_o | output | 1 | Registered underflow flag |
| inexact_o | output | 1 | Registered inexact flag |

## Verification
Every result and flag is due exactly one rising edge after its operands are applied, because the only registers are the output registers. The bench changes operands on a falling edge and compares the outputs at the next falling edge. Each comparison therefore sees the value captured at the single rising edge between the two. The reset checks sample on falling edges while reset is held, and again after a mid-stream reset pulse, with nonzero operands on the inputs. The bound properties use the same one-edge relation, pairing each output with the operands held one sampled edge earlier.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fflags_t;
endpackage

// File: rtl/fpas_unpack.sv
module fpas_unpack #(
  parameter int EXP_W = fpas_pkg::FP_EXP_W,
  parameter int MAN_W = fpas_pkg::FP_MAN_W
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  input  logic                 flip_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       sig_o,
  output logic                 inf_o,
  output logic                 nan_o,
  output logic                 snan_o
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] raw_exp;
  logic [MAN_W-1:0] raw_frac;
  logic             exp_ones, exp_zero, frac_zero;

  assign raw_exp   = word_i[W-2:MAN_W];
  assign raw_frac  = word_i[MAN_W-1:0];
  assign exp_ones  = &raw_exp;
  assign exp_zero  = ~|raw_exp;
  assign frac_zero = ~|raw_frac;

  assign sign_o = word_i[W-1] ^ flip_i;
  // subnormals: implicit leading 0, exponent taken as 1
  assign exp_o  = exp_zero ? EXP_W'(1) : raw_exp;
  assign sig_o  = {~exp_zero, raw_frac};
  assign inf_o  = exp_ones & frac_zero;
  assign nan_o  = exp_ones & ~frac_zero;
  assign snan_o = nan_o & ~raw_frac[MAN_W-1];
endmodule

// File: rtl/fpas_align_add.sv
module fpas_align_add #(
  parameter int EXP_W = fpas_pkg::FP_EXP_W,
  parameter int MAN_W = fpas_pkg::FP_MAN_W
) (
  input  logic               sa_i,
  input  logic [EXP_W-1:0]   ea_i,
  input  logic [MAN_W:0]     siga_i,
  input  logic               sb_i,
  input  logic [EXP_W-1:0]   eb_i,
  input  logic [MAN_W:0]     sigb_i,
  output logic [MAN_W+4:0]   sum_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               sign_o
);
  // significand plus guard, round, sticky
  localparam int EXT = MAN_W + 4;

  logic             a_big, eff_sub;
  logic [EXP_W-1:0] e_big, e_small, diff, sh_amt;
  logic [MAN_W:0]   sig_big, sig_small;
  logic [EXT-1:0]   big_ext, small_ext, aligned;
  logic [2*EXT-1:0] wide;
  logic             sticky;

  assign a_big     = {ea_i, siga_i} >= {eb_i, sigb_i};
  assign e_big     = a_big ? ea_i : eb_i;
  assign e_small   = a_big ? eb_i : ea_i;
  assign sig_big   = a_big ? siga_i : sigb_i;
  assign sig_small = a_big ? sigb_i : siga_i;
  assign sign_o    = a_big ? sa_i : sb_i;
  assign eff_sub   = sa_i ^ sb_i;

  assign diff    = e_big - e_small;
  assign sh_amt  = (diff > EXP_W'(EXT)) ? EXP_W'(EXT) : diff;
  assign wide    = {sig_small, 3'b000, {EXT{1'b0}}} >> sh_amt;
  assign aligned = wide[2*EXT-1:EXT];
  assign sticky  = |wide[EXT-1:0];

  assign big_ext   = {sig_big, 3'b000};
  assign small_ext = {aligned[EXT-1:1], aligned[0] | sticky};

  assign sum_o = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                         : ({1'b0, big_ext} + {1'b0, small_ext});
  assign exp_o = e_big;
endmodule

// File: rtl/fpas_norm_round.sv
module fpas_norm_round
  import fpas_pkg::*;
#(
  parameter int EXP_W = fpas_pkg::FP_EXP_W,
  parameter int MAN_W = fpas_pkg::FP_MAN_W
) (
  input  logic [MAN_W+4:0]   sum_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic               sign_i,
  input  rmode_e             rm_i,
  output logic [EXP_W+MAN_W:0] word_o,
  output fflags_t            flags_o
);
  localparam int EXT = MAN_W + 4;
  localparam int EW  = EXP_W + 2;
  localparam int LZW = $clog2(EXT + 1);
  localparam logic [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);

  logic [LZW-1:0]   lz;
  logic [EW-1:0]    e_lim, e_pre, e_post;
  logic [EXT-1:0]   norm;
  logic [MAN_W:0]   mant;
  logic [MAN_W+1:0] mr;
  logic [MAN_W-1:0] frac;
  logic             g, rs, rup, inx, tiny, ovf, to_inf;

  always_comb begin
    lz = LZW'(EXT);
    for (int i = 0; i < EXT; i++) begin
      if (sum_i[i]) lz = LZW'(EXT - 1 - i);
    end
  end

  always_comb begin
    e_lim = EW'(exp_i) - EW'(1);
    if (sum_i[EXT]) begin
      norm  = {sum_i[EXT:2], |sum_i[1:0]};
      e_pre = EW'(exp_i) + EW'(1);
    end else if (EW'(lz) <= e_lim) begin
      norm  = sum_i[EXT-1:0] << lz;
      e_pre = EW'(exp_i) - EW'(lz);
    end else begin
      norm  = sum_i[EXT-1:0] << e_lim;
      e_pre = EW'(1);
    end

    mant = norm[EXT-1:3];
    g    = norm[2];
    rs   = |norm[1:0];
    inx  = g | rs;
    tiny = ~norm[EXT-1];

    unique case (rm_i)
      RM_NEAREST: rup = g & (rs | mant[0]);
      RM_ZERO:    rup = 1'b0;
      RM_UP:      rup = ~sign_i & inx;
      default:    rup = sign_i & inx;
    endcase

    mr = {1'b0, mant} + (MAN_W+2)'(rup);
    if (mr[MAN_W+1]) begin
      e_post = e_pre + EW'(1);
      frac   = mr[MAN_W:1];
    end else begin
      e_post = mr[MAN_W] ? e_pre : '0;
      frac   = mr[MAN_W-1:0];
    end

    ovf    = e_post >= EMAX;
    to_inf = (rm_i == RM_NEAREST) || (rm_i == RM_UP && !sign_i) ||
             (rm_i == RM_DOWN && sign_i);

    flags_o.invalid   = 1'b0;
    flags_o.overflow  = ovf;
    flags_o.underflow = tiny & inx;
    flags_o.inexact   = inx | ovf;
    if (ovf)
      word_o = to_inf ? {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                      : {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
    else
      word_o = {sign_i, e_post[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpas_top.sv
module fpas_top
  import fpas_pkg::*;
#(
  parameter int EXP_W = fpas_pkg::FP_EXP_W,
  parameter int MAN_W = fpas_pkg::FP_MAN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+MAN_W:0] in_a,
  input  logic [EXP_W+MAN_W:0] in_b,
  input  logic                 sub_sel,
  input  logic [1:0]           rnd_mode,
  output logic [EXP_W+MAN_W:0] sum_out,
  output logic                 invalid_o,
  output logic                 overflow_o,
  output logic                 underflow_o,
  output logic                 inexact_o
);
  localparam int W   = EXP_W + MAN_W + 1;
  localparam int EXT = MAN_W + 4;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  rmode_e rm;
  assign rm = rmode_e'(rnd_mode);

  logic             sa, sb, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
  logic [EXP_W-1:0] ea, eb, e_big;
  logic [MAN_W:0]   siga, sigb;
  logic [EXT:0]     sum;
  logic             s_big;
  logic [W-1:0]     num_word, nxt_word;
  fflags_t          num_flags, nxt_flags;

  fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_a_i (
    .word_i(in_a), .flip_i(1'b0), .sign_o(sa), .exp_o(ea), .sig_o(siga),
    .inf_o(a_inf), .nan_o(a_nan), .snan_o(a_snan));

  // subtraction: second operand enters with its sign inverted
  fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_b_i (
    .word_i(in_b), .flip_i(sub_sel), .sign_o(sb), .exp_o(eb), .sig_o(sigb),
    .inf_o(b_inf), .nan_o(b_nan), .snan_o(b_snan));

  fpas_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) align_i (
    .sa_i(sa), .ea_i(ea), .siga_i(siga), .sb_i(sb), .eb_i(eb), .sigb_i(sigb),
    .sum_o(sum), .exp_o(e_big), .sign_o(s_big));

  fpas_norm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) round_i (
    .sum_i(sum), .exp_i(e_big), .sign_i(s_big), .rm_i(rm),
    .word_o(num_word), .flags_o(num_flags));

  always_comb begin
    nxt_flags = '0;
    if (a_nan || b_nan) begin
      nxt_word          = QNAN;
      nxt_flags.invalid = a_snan | b_snan;
    end else if (a_inf && b_inf && (sa != sb)) begin
      nxt_word          = QNAN;
      nxt_flags.invalid = 1'b1;
    end else if (a_inf) begin
      nxt_word = {sa, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (b_inf) begin
      nxt_word = {sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (sum == '0) begin
      nxt_word = {(sa == sb) ? sa : (rm == RM_DOWN), {(W-1){1'b0}}};
    end else begin
      nxt_word  = num_word;
      nxt_flags = num_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out     <= '0;
      invalid_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      sum_out     <= nxt_word;
      invalid_o   <= nxt_flags.invalid;
      overflow_o  <= nxt_flags.overflow;
      underflow_o <= nxt_flags.underflow;
      inexact_o   <= nxt_flags.inexact;
    end
  end
endmodule

// File: rtl/fpas_chk.sv
module fpas_chk #(
  parameter int EXP_W = fpas_pkg::FP_EXP_W,
  parameter int MAN_W = fpas_pkg::FP_MAN_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic                 sub_sel,
  input logic [1:0]           rnd_mode,
  input logic [EXP_W+MAN_W:0] sum_out,
  input logic                 invalid_o,
  input logic                 overflow_o,
  input logic                 underflow_o,
  input logic                 inexact_o
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, b_nan, a_inf, b_inf, a_fin, b_fin;
  assign a_nan = (&in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]);
  assign b_nan = (&in_b[W-2:MAN_W]) && (|in_b[MAN_W-1:0]);
  assign a_inf = (&in_a[W-2:MAN_W]) && !(|in_a[MAN_W-1:0]);
  assign b_inf = (&in_b[W-2:MAN_W]) && !(|in_b[MAN_W-1:0]);
  assign a_fin = !(&in_a[W-2:MAN_W]);
  assign b_fin = !(&in_b[W-2:MAN_W]);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_out == '0 && !invalid_o && !overflow_o && !underflow_o && !inexact_o));

  assert_nan_result_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_nan || b_nan)) |-> sum_out == QNAN);

  assert_inf_cancel_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_inf && b_inf && ((in_a[W-1] ^ in_b[W-1] ^ sub_sel) == 1'b1)))
      |-> (invalid_o && sum_out == QNAN));

  assert_self_diff_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sub_sel && in_a == in_b && a_fin && b_fin))
      |-> sum_out == {($past(rnd_mode) == 2'b11), {(W-1){1'b0}}});

  assert_ovf_inexact_R9: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> inexact_o);

  assert_invalid_alone_R10: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> (!overflow_o && !inexact_o && !underflow_o));
endmodule

bind fpas_top fpas_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
  .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .sub_sel(sub_sel),
  .rnd_mode(rnd_mode), .sum_out(sum_out), .invalid_o(invalid_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .inexact_o(inexact_o));

// File: tb/fpas_top_tb_top.sv
module fpas_top_tb_top;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        op;
    logic [1:0]  rm;
    logic [31:0] res;
    logic [3:0]  flg;  // {invalid, overflow, underflow, inexact}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{32'h40400000, 32'h40000000, 1'b0, 2'd0, 32'h40A00000, 4'h0, 4'd2},  // R2 3+2
    '{32'h40400000, 32'h40000000, 1'b1, 2'd0, 32'h3F800000, 4'h0, 4'd2},  // R2 3-2
    '{32'h40000000, 32'h40400000, 1'b1, 2'd0, 32'hBF800000, 4'h0, 4'd2},  // R2 2-3
    '{32'h3F800000, 32'h3F800000, 1'b1, 2'd0, 32'h00000000, 4'h0, 4'd5},  // R5
    '{32'h3F800000, 32'h3F800000, 1'b1, 2'd3, 32'h80000000, 4'h0, 4'd5},  // R5 toward -inf
    '{32'h3F800000, 32'h3F800000, 1'b1, 2'd2, 32'h00000000, 4'h0, 4'd5},  // R5
    '{32'h80000000, 32'h80000000, 1'b0, 2'd1, 32'h80000000, 4'h0, 4'd5},  // R5 -0 + -0
    '{32'h80000000, 32'h80000000, 1'b1, 2'd0, 32'h00000000, 4'h0, 4'd5},  // R5 -0 - -0
    '{32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000, 4'h8, 4'd4},  // R4
    '{32'hFF800000, 32'hFF800000, 1'b1, 2'd0, 32'h7FC00000, 4'h8, 4'd4},  // R4
    '{32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 32'h7FC00000, 4'h8, 4'd4},  // R4
    '{32'h7F800000, 32'hFF800000, 1'b1, 2'd0, 32'h7F800000, 4'h0, 4'd4},  // R4
    '{32'hFF800000, 32'h7F800000, 1'b1, 2'd0, 32'hFF800000, 4'h0, 4'd4},  // R4
    '{32'h3F800000, 32'h7F800000, 1'b1, 2'd0, 32'hFF800000, 4'h0, 4'd4},  // R4 1-inf
    '{32'h7FC00000, 32'h3F800000, 1'b1, 2'd0, 32'h7FC00000, 4'h0, 4'd3},  // R3
    '{32'h3F800000, 32'h7FC12345, 1'b0, 2'd0, 32'h7FC00000, 4'h0, 4'd3},  // R3
    '{32'h7F800001, 32'h3F800000, 1'b0, 2'd0, 32'h7FC00000, 4'h8, 4'd3},  // R3 signalling
    '{32'h7FC00000, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000, 4'h0, 4'd3},  // R3 NaN over inf
    '{32'h00000000, 32'h40400000, 1'b1, 2'd0, 32'hC0400000, 4'h0, 4'd6},  // R6 0-x
    '{32'h40400000, 32'h00000000, 1'b1, 2'd0, 32'h40400000, 4'h0, 4'd6},  // R6 x-0
    '{32'h3F800000, 32'h33800000, 1'b0, 2'd0, 32'h3F800000, 4'h1, 4'd7},  // R7 tie even
    '{32'h3F800000, 32'h33800000, 1'b0, 2'd2, 32'h3F800001, 4'h1, 4'd7},  // R7 up
    '{32'h3F800000, 32'h33C00000, 1'b0, 2'd1, 32'h3F800000, 4'h1, 4'd7},  // R7 zero
    '{32'h3F800000, 32'h33C00000, 1'b0, 2'd0, 32'h3F800001, 4'h1, 4'd7},  // R7 nearest
    '{32'h3F800001, 32'h33800000, 1'b0, 2'd0, 32'h3F800002, 4'h1, 4'd7},  // R7 tie odd
    '{32'h3F800000, 32'h00000001, 1'b0, 2'd2, 32'h3F800001, 4'h1, 4'd7},  // R7 sticky only
    '{32'hBF800000, 32'h00000001, 1'b1, 2'd3, 32'hBF800001, 4'h1, 4'd7},  // R7 down
    '{32'h3F800000, 32'h33800000, 1'b1, 2'd0, 32'h3F7FFFFF, 4'h0, 4'd8},  // R8
    '{32'h3FC00000, 32'h3F800001, 1'b1, 2'd0, 32'h3EFFFFFC, 4'h0, 4'd8},  // R8 Sterbenz
    '{32'h3F800001, 32'h3F800000, 1'b1, 2'd1, 32'h34000000, 4'h0, 4'd8},  // R8 cancel
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0, 32'h7F800000, 4'h5, 4'd9},  // R9
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd1, 32'h7F7FFFFF, 4'h5, 4'd9},  // R9
    '{32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 2'd2, 32'hFF7FFFFF, 4'h5, 4'd9},  // R9
    '{32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 2'd3, 32'hFF800000, 4'h5, 4'd9},  // R9
    '{32'h00000001, 32'h00000001, 1'b0, 2'd0, 32'h00000002, 4'h0, 4'd10}, // R10
    '{32'h00800000, 32'h00000001, 1'b1, 2'd0, 32'h007FFFFF, 4'h0, 4'd10}, // R10
    '{32'h007FFFFF, 32'h00000001, 1'b0, 2'd0, 32'h00800000, 4'h0, 4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_a = '0, in_b = '0;
  logic        sub_sel = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic [31:0] sum_out;
  logic        invalid_o, overflow_o, underflow_o, inexact_o;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fpas_top dut_i (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .sub_sel(sub_sel),
    .rnd_mode(rnd_mode), .sum_out(sum_out), .invalid_o(invalid_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o), .inexact_o(inexact_o));

  task automatic compare(input int req, input logic [31:0] er, input logic [3:0] ef);
    logic [3:0] af;
    af = {invalid_o, overflow_o, underflow_o, inexact_o};
    n_chk++;
    if (sum_out !== er || af !== ef) begin
      n_bad++;
      $display("FAIL R%0d: got %h flags %b, expected %h flags %b", req, sum_out, af, er, ef);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_a = v.a; in_b = v.b; sub_sel = v.op; rnd_mode = v.rm;
    @(negedge clk);  // one rising edge later the registers hold the result
    compare(int'(v.req), v.res, v.flg);
  endtask

  initial begin
    // R1: outputs held at zero during reset, even with live operands
    in_a = 32'h40400000; in_b = 32'h40000000;
    repeat (3) begin
      @(negedge clk);
      compare(1, 32'h0, 4'h0);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R1: back-to-back operands, each result one edge later
    @(negedge clk);
    in_a = 32'h3F800000; in_b = 32'h3F800000; sub_sel = 1'b0; rnd_mode = 2'd0;
    @(negedge clk);
    compare(1, 32'h40000000, 4'h0);
    in_a = 32'h7F7FFFFF; in_b = 32'h7F7FFFFF;
    @(negedge clk);
    compare(1, 32'h7F800000, 4'h5);

    // R1: mid-stream reset clears outputs
    rst = 1'b1;
    @(negedge clk);
    compare(1, 32'h0, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    compare(1, 32'h7F800000, 4'h5);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R1: watchdog expired, got no completion, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule